// File: doc/BRIEF.md
# I2C Master Event Sequencer

This block is the bus-side engine of an I2C master. Software, or a small controller above it, asks for one bus event at a time with a single-cycle strobe. The events are a START, a repeated START, a STOP, the reception of one byte, the sending of one acknowledge bit, and the transmission of one byte, which is started by a write to the data buffer. The block drives the open-drain SCL and SDA lines through pull-low enables, reads both lines back through a two-stage synchronizer, and reports each finished event through a sticky completion flag.

Events are never queued. A request that arrives while an event is running is refused and raises a sticky write-collision flag. While the master releases SDA to send a 1, it compares the line with that value. If it reads a 0, it has lost arbitration: it aborts the event, releases both lines, returns to idle and raises a sticky bus-collision flag. The bit rate comes from a reload value. Every bit lasts four quarter periods of (reload + 1) clocks each, which gives f_scl = f_clk / (4 * (reload + 1)). For example, 16 MHz with a reload of 9 gives 400 kHz.

When several strobes arrive in the same idle cycle, only one is taken. The order is START, then repeated START, STOP, receive, acknowledge, and buffer write last.

Top module: `i2c_evt_master`

## Requirements
- R1: A strobe or buffer write that arrives while `busy` is high sets `wr_coll`. It leaves `buf_rdata` unchanged, does not raise `evt_done`, and does not disturb the running event. `wr_coll` stays set until `wr_coll_clr`.
- R2: During data bits, SCL is high for 2*(rate_i+1) clocks and low for 2*(rate_i+1) clocks.
- R3: A byte write puts the 8 bits of `buf_wdata` on SDA, MSB first, then releases SDA for a ninth clock. The SDA level sampled on that ninth clock is stored in `ack_rx` (0 = ACK, 1 = NACK).
- R4: A receive generates 8 clocks with SDA released. It loads the sampled bits, MSB first, into `buf_rdata`, and `busy` clears by itself at the end.
- R5: An acknowledge event generates one clock and drives `ack_drive` onto SDA during it (0 = pull low, 1 = release).
- R6: START makes SDA fall while SCL is high, then pulls SCL low. A repeated START first releases SDA and then SCL, and then performs the same fall. STOP pulls SDA low while SCL is low, releases SCL, and then releases SDA while SCL is high, which leaves both lines released.
- R7: `evt_done` is set when any event finishes normally, and it stays set until `evt_done_clr`.
- R8: On arbitration loss, both lines are released, `busy` and `tx_full` drop, and `arb_lost` is set while `evt_done` stays clear. A released SDA read low on the mid-high sample of a transmitted 1, at START/repeated-START setup, or at the end of STOP counts as arbitration loss.
- R9: Inside a byte or acknowledge event, SDA changes only while SCL is held low, so no START or STOP appears on the bus.
- R10: `tx_full` rises on an accepted buffer write and falls when that write event ends or is aborted.
- R11: After reset, both lines are released and `busy`, `tx_full`, `evt_done`, `wr_coll` and `arb_lost` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_i | input | RATE_W | Quarter-period reload value; one quarter lasts rate_i+1 clocks |
| cmd_start | input | 1 | Strobe: START condition |
| cmd_rstart | input | 1 | Strobe: repeated START |
| cmd_stop | input | 1 | Strobe: STOP condition |
| cmd_rcv | input | 1 | Strobe: receive one byte |
| cmd_ack | input | 1 | Strobe: send one acknowledge bit |
| ack_drive | input | 1 | Acknowledge value for cmd_ack (0 ACK, 1 NACK) |
| buf_wr | input | 1 | Write strobe for the data buffer; starts a byte transmission |
| buf_wdata | input | DATA_W | Byte to transmit |
| buf_rdata | output | DATA_W | Data buffer: last accepted write or last received byte |
| busy | output | 1 | An event is in progress |
| tx_full | output | 1 | Transmit byte pending or shifting |
| ack_rx | output | 1 | Acknowledge bit sampled after the last transmitted byte |
| evt_done | output | 1 | Sticky event-completion flag |
| evt_done_clr | input | 1 | Clears evt_done |
| wr_coll | output | 1 | Sticky write-collision flag |
| wr_coll_clr | input | 1 | Clears wr_coll |
| arb_lost | output | 1 | Sticky bus-collision flag |
| arb_lost_clr | input | 1 | Clears arb_lost |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
The hardest situation to reach from the ports is arbitration loss in the middle of a transmit. It needs a second bus agent that holds SDA low at the exact point where the master has released it to send a 1. The bench models that rival as an extra pull-down on the SDA wire. The rival pulls SDA low after a START, while SCL is held low, and then a byte whose MSB is 1 is written, so the loss happens on the first mid-high sample. Refused requests are placed in the gap before the first SCL rise of a running event. Their lack of effect is then read from the bus frames and the data buffer.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_START,
    EV_RSTART,
    EV_STOP,
    EV_RECV,
    EV_ACK,
    EV_WRITE
  } ev_kind_t;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_S_REL,    // START: both lines released, bus checked
    SQ_S_SDA,    // START: SDA low with SCL high
    SQ_S_SCL,    // START: SCL pulled low
    SQ_R_SDA,    // repeated START: SDA released, SCL low
    SQ_R_SCL,    // repeated START: SCL released
    SQ_P_SDA,    // STOP: SDA low, SCL low
    SQ_P_SCL,    // STOP: SCL released
    SQ_P_REL,    // STOP: SDA released
    SQ_BIT       // data / acknowledge bits, four quarters each
  } seq_state_t;

endpackage

// File: rtl/i2c_evt_sync.sv
module i2c_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = STAGES'({sh_q, d});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/i2c_evt_baud.sv
module i2c_evt_baud #(
  parameter int RATE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] cnt_d;

  assign tick = run && !load && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = rate;
    end else if (run) begin
      if (cnt_q == '0) cnt_d = rate;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R2: a nonzero reload never produces back-to-back quarter ticks
  assert_quarter_spacing_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rate != '0) |=> !tick);

endmodule

// File: rtl/i2c_evt_seq.sv
module i2c_evt_seq
  import i2c_evt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  ev_kind_t          ev,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              ack_val,
  input  logic              tick,
  input  logic              scl_s,
  input  logic              sda_s,
  output logic              active,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              fin_p,
  output logic              lost_p,
  output logic              rx_p,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ack_p,
  output logic              ack_bit
);

  localparam int CNT_W = $clog2(DATA_W + 2);

  seq_state_t       st_q, st_d;
  ev_kind_t         ev_q, ev_d;
  logic [1:0]       qtr_q, qtr_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [DATA_W:0]  sh_q, sh_d;
  logic             scl_oe_q, scl_oe_d;
  logic             sda_oe_q, sda_oe_d;
  logic             lose;
  logic             arb_chk;
  logic             last_bit;

  assign active  = (st_q != SQ_IDLE);
  assign scl_oe  = scl_oe_q;
  assign sda_oe  = sda_oe_q;
  assign rx_byte = sh_q[DATA_W-1:0];
  assign ack_bit = sda_s;

  assign last_bit = (left_q == CNT_W'(1));
  // the master is the transmitter for every bit except received data and the slave's ACK slot
  assign arb_chk  = (ev_q != EV_RECV) && !((ev_q == EV_WRITE) && last_bit);

  always_comb begin
    st_d     = st_q;
    ev_d     = ev_q;
    qtr_d    = qtr_q;
    left_d   = left_q;
    sh_d     = sh_q;
    scl_oe_d = scl_oe_q;
    sda_oe_d = sda_oe_q;
    fin_p    = 1'b0;
    rx_p     = 1'b0;
    ack_p    = 1'b0;
    lose     = 1'b0;

    case (st_q)
      SQ_IDLE: begin
        if (go) begin
          ev_d  = ev;
          qtr_d = 2'd0;
          case (ev)
            EV_START: begin
              st_d = SQ_S_REL; scl_oe_d = 1'b0; sda_oe_d = 1'b0;
            end
            EV_RSTART: begin
              st_d = SQ_R_SDA; sda_oe_d = 1'b0;
            end
            EV_STOP: begin
              st_d = SQ_P_SDA; sda_oe_d = 1'b1;
            end
            EV_RECV: begin
              st_d = SQ_BIT; left_d = CNT_W'(DATA_W); sh_d = '1;
            end
            EV_ACK: begin
              st_d = SQ_BIT; left_d = CNT_W'(1); sh_d = {ack_val, {DATA_W{1'b1}}};
            end
            EV_WRITE: begin
              st_d = SQ_BIT; left_d = CNT_W'(DATA_W + 1); sh_d = {tx_byte, 1'b1};
            end
            default: st_d = SQ_IDLE;
          endcase
        end
      end
      SQ_S_REL: if (tick) begin
        if (!sda_s || !scl_s) lose = 1'b1;
        else begin st_d = SQ_S_SDA; sda_oe_d = 1'b1; end
      end
      SQ_S_SDA: if (tick) begin
        st_d = SQ_S_SCL; scl_oe_d = 1'b1;
      end
      SQ_S_SCL: if (tick) begin
        st_d = SQ_IDLE; fin_p = 1'b1;
      end
      SQ_R_SDA: if (tick) begin
        st_d = SQ_R_SCL; scl_oe_d = 1'b0;
      end
      SQ_R_SCL: if (tick) begin
        if (!sda_s || !scl_s) lose = 1'b1;
        else begin st_d = SQ_S_SDA; sda_oe_d = 1'b1; end
      end
      SQ_P_SDA: if (tick) begin
        st_d = SQ_P_SCL; scl_oe_d = 1'b0;
      end
      SQ_P_SCL: if (tick) begin
        st_d = SQ_P_REL; sda_oe_d = 1'b0;
      end
      SQ_P_REL: if (tick) begin
        if (!sda_s) lose = 1'b1;
        else begin st_d = SQ_IDLE; fin_p = 1'b1; end
      end
      SQ_BIT: if (tick) begin
        case (qtr_q)
          2'd0: begin
            qtr_d    = 2'd1;
            sda_oe_d = !sh_q[DATA_W];
          end
          2'd1: begin
            qtr_d    = 2'd2;
            scl_oe_d = 1'b0;
          end
          2'd2: begin
            qtr_d = 2'd3;
            sh_d  = {sh_q[DATA_W-1:0], sda_s};
            if ((ev_q == EV_WRITE) && last_bit) ack_p = 1'b1;
            if (arb_chk && sh_q[DATA_W] && !sda_s) lose = 1'b1;
          end
          default: begin
            scl_oe_d = 1'b1;
            if (last_bit) begin
              st_d  = SQ_IDLE;
              fin_p = 1'b1;
              rx_p  = (ev_q == EV_RECV);
            end else begin
              left_d = left_q - 1'b1;
              qtr_d  = 2'd0;
            end
          end
        endcase
      end
      default: st_d = SQ_IDLE;
    endcase

    if (lose) begin
      st_d     = SQ_IDLE;
      scl_oe_d = 1'b0;
      sda_oe_d = 1'b0;
      ack_p    = 1'b0;
    end
  end

  assign lost_p = lose;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      ev_q     <= EV_NONE;
      qtr_q    <= 2'd0;
      left_q   <= '0;
      sh_q     <= '1;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      ev_q     <= ev_d;
      qtr_q    <= qtr_d;
      left_q   <= left_d;
      sh_q     <= sh_d;
      scl_oe_q <= scl_oe_d;
      sda_oe_q <= sda_oe_d;
    end
  end

  // R9: inside bit events SDA moves only while SCL has been held low
  assert_sda_moves_scl_low_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_BIT && !$stable(sda_oe_q)) |-> (scl_oe_q && $past(scl_oe_q)));

  // R8: an arbitration loss leaves the sequencer idle with both lines free
  assert_loss_frees_lines_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    lost_p |=> (st_q == SQ_IDLE && !scl_oe_q && !sda_oe_q));

endmodule

// File: rtl/i2c_evt_master.sv
module i2c_evt_master
  import i2c_evt_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RATE_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              cmd_start,
  input  logic              cmd_rstart,
  input  logic              cmd_stop,
  input  logic              cmd_rcv,
  input  logic              cmd_ack,
  input  logic              ack_drive,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  output logic [DATA_W-1:0] buf_rdata,
  output logic              busy,
  output logic              tx_full,
  output logic              ack_rx,
  output logic              evt_done,
  input  logic              evt_done_clr,
  output logic              wr_coll,
  input  logic              wr_coll_clr,
  output logic              arb_lost,
  input  logic              arb_lost_clr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw;
  logic [NLINES-1:0] line_s;

  assign line_raw = {sda_in, scl_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    i2c_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (line_raw[g]),
      .q     (line_s[g])
    );
  end

  ev_kind_t          ev_sel;
  logic              any_req;
  logic              accept;
  logic              reject;
  logic              seq_active;
  logic              tick;
  logic              fin_p, lost_p, rx_p, ack_p, ack_bit;
  logic [DATA_W-1:0] rx_byte;

  logic [DATA_W-1:0] dbuf_q, dbuf_d;
  logic              txf_q, txf_d;
  logic              ackrx_q, ackrx_d;
  logic              done_q, done_d;
  logic              wcol_q, wcol_d;
  logic              blost_q, blost_d;

  always_comb begin
    if (cmd_start)       ev_sel = EV_START;
    else if (cmd_rstart) ev_sel = EV_RSTART;
    else if (cmd_stop)   ev_sel = EV_STOP;
    else if (cmd_rcv)    ev_sel = EV_RECV;
    else if (cmd_ack)    ev_sel = EV_ACK;
    else if (buf_wr)     ev_sel = EV_WRITE;
    else                 ev_sel = EV_NONE;
  end

  assign any_req = (ev_sel != EV_NONE);
  assign accept  = any_req && !seq_active;
  assign reject  = any_req && seq_active;

  i2c_evt_baud #(.RATE_W(RATE_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .run   (seq_active),
    .rate  (rate_i),
    .tick  (tick)
  );

  i2c_evt_seq #(.DATA_W(DATA_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (accept),
    .ev      (ev_sel),
    .tx_byte (buf_wdata),
    .ack_val (ack_drive),
    .tick    (tick),
    .scl_s   (line_s[0]),
    .sda_s   (line_s[1]),
    .active  (seq_active),
    .scl_oe  (scl_drive_low),
    .sda_oe  (sda_drive_low),
    .fin_p   (fin_p),
    .lost_p  (lost_p),
    .rx_p    (rx_p),
    .rx_byte (rx_byte),
    .ack_p   (ack_p),
    .ack_bit (ack_bit)
  );

  always_comb begin
    dbuf_d  = dbuf_q;
    txf_d   = txf_q;
    ackrx_d = ackrx_q;
    done_d  = done_q;
    wcol_d  = wcol_q;
    blost_d = blost_q;

    if (accept && ev_sel == EV_WRITE) dbuf_d = buf_wdata;
    else if (rx_p)                    dbuf_d = rx_byte;

    if (accept && ev_sel == EV_WRITE) txf_d = 1'b1;
    else if (fin_p || lost_p)         txf_d = 1'b0;

    if (ack_p) ackrx_d = ack_bit;

    if (fin_p)             done_d = 1'b1;
    else if (evt_done_clr) done_d = 1'b0;

    if (reject)           wcol_d = 1'b1;
    else if (wr_coll_clr) wcol_d = 1'b0;

    if (lost_p)            blost_d = 1'b1;
    else if (arb_lost_clr) blost_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbuf_q  <= '0;
      txf_q   <= 1'b0;
      ackrx_q <= 1'b1;
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
      blost_q <= 1'b0;
    end else begin
      dbuf_q  <= dbuf_d;
      txf_q   <= txf_d;
      ackrx_q <= ackrx_d;
      done_q  <= done_d;
      wcol_q  <= wcol_d;
      blost_q <= blost_d;
    end
  end

  assign buf_rdata = dbuf_q;
  assign busy      = seq_active;
  assign tx_full   = txf_q;
  assign ack_rx    = ackrx_q;
  assign evt_done  = done_q;
  assign wr_coll   = wcol_q;
  assign arb_lost  = blost_q;

  // R1: the collision flag only rises after a request met a busy sequencer
  assert_wcol_needs_busy_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_coll) |-> $past(busy));

  // R1: a refused buffer write leaves the buffer untouched
  assert_refused_write_keeps_buf_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && busy && !rx_p) |=> $stable(buf_rdata));

  // R7: completion appears exactly as an event winds down
  assert_done_at_event_end_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_done) |-> ($past(busy) && !busy));

  // R8: collision flag comes with an idle block and released lines
  assert_lost_state_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (!busy && !scl_drive_low && !sda_drive_low && !tx_full && !$rose(evt_done)));

  // R10: a pending transmit byte always has a running event
  assert_txfull_busy_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> busy);

endmodule

// File: tb/i2c_evt_master_bench.sv
module i2c_evt_master_bench;

  localparam int DW = 8;
  localparam int RW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic [RW-1:0] rate;
  logic          c_start, c_rstart, c_stop, c_rcv, c_ack, ack_val, c_wr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          busy, tx_full, ack_rx, done, wcol, blost;
  logic          done_clr, wcol_clr, blost_clr;
  logic          scl_drv, sda_drv;
  logic          slv_sda_low, rival_sda_low;
  logic          scl_line, sda_line;

  assign scl_line = ~scl_drv;
  assign sda_line = ~(sda_drv | slv_sda_low | rival_sda_low);

  i2c_evt_master #(.DATA_W(DW), .RATE_W(RW)) u_i2c_evt_master (
    .clk           (clk),
    .rst_n         (rst_n),
    .rate_i        (rate),
    .cmd_start     (c_start),
    .cmd_rstart    (c_rstart),
    .cmd_stop      (c_stop),
    .cmd_rcv       (c_rcv),
    .cmd_ack       (c_ack),
    .ack_drive     (ack_val),
    .buf_wr        (c_wr),
    .buf_wdata     (wdata),
    .buf_rdata     (rdata),
    .busy          (busy),
    .tx_full       (tx_full),
    .ack_rx        (ack_rx),
    .evt_done      (done),
    .evt_done_clr  (done_clr),
    .wr_coll       (wcol),
    .wr_coll_clr   (wcol_clr),
    .arb_lost      (blost),
    .arb_lost_clr  (blost_clr),
    .scl_in        (scl_line),
    .sda_in        (sda_line),
    .scl_drive_low (scl_drv),
    .sda_drive_low (sda_drv)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard: expected 9-bit frames {byte, ninth bit}
  logic [8:0] exp_q[$];
  logic [8:0] mshift = '0;
  int         mbits  = 0;
  int         starts = 0;
  int         stops  = 0;

  always @(negedge sda_line) if (scl_line === 1'b1) begin starts++; mbits = 0; end
  always @(posedge sda_line) if (scl_line === 1'b1) stops++;

  always @(posedge scl_line) begin
    mshift = {mshift[7:0], sda_line};
    mbits++;
    if (mbits == 9) begin
      mbits = 0;
      if (exp_q.size() == 0) chk("R3 unexpected bus frame", 1, 0);
      else chk("R3 R4 R5 bus frame", int'(mshift), int'(exp_q.pop_front()));
    end
  end

  task automatic fire(input logic [5:0] m, input logic [DW-1:0] d);
    @(negedge clk);
    {c_start, c_rstart, c_stop, c_rcv, c_ack, c_wr} = m;
    wdata = d;
    @(negedge clk);
    {c_start, c_rstart, c_stop, c_rcv, c_ack, c_wr} = '0;
  endtask

  localparam logic [5:0] M_START  = 6'b100000;
  localparam logic [5:0] M_RSTART = 6'b010000;
  localparam logic [5:0] M_STOP   = 6'b001000;
  localparam logic [5:0] M_RCV    = 6'b000100;
  localparam logic [5:0] M_ACK    = 6'b000010;
  localparam logic [5:0] M_WR     = 6'b000001;

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  task automatic clear_flags();
    @(negedge clk);
    done_clr = 1'b1; wcol_clr = 1'b1; blost_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0; wcol_clr = 1'b0; blost_clr = 1'b0;
  endtask

  task automatic slave_ack(input logic a);
    repeat (8) @(posedge scl_line);
    @(negedge scl_line);
    slv_sda_low = ~a;
    @(negedge scl_line);
    slv_sda_low = 1'b0;
  endtask

  task automatic slave_send(input logic [7:0] b);
    for (int i = 6; i >= 0; i--) begin
      @(negedge scl_line);
      slv_sda_low = ~b[i];
    end
    @(negedge scl_line);
    slv_sda_low = 1'b0;
  endtask

  task automatic measure_bit(input string tag, input int exp_len);
    int t0, t1, t2;
    @(posedge scl_line); t0 = cyc;
    @(negedge scl_line); t1 = cyc;
    @(posedge scl_line); t2 = cyc;
    chk({tag, " SCL high length"}, t1 - t0, exp_len);
    chk({tag, " SCL low length"}, t2 - t1, exp_len);
  endtask

  task automatic do_write(input logic [7:0] b, input logic a);
    exp_q.push_back({b, a});
    fork
      slave_ack(a);
      fire(M_WR, b);
    join
    wait_idle();
  endtask

  task automatic do_read(input logic [7:0] b, input logic a);
    exp_q.push_back({b, a});
    slv_sda_low = ~b[7];
    fork
      slave_send(b);
      fire(M_RCV, 8'h00);
    join
    wait_idle();
    chk("R4 received byte in buffer", rdata, b);
    chk("R4 busy cleared after receive", busy, 0);
    clear_flags();
    ack_val = a;
    fire(M_ACK, 8'h00);
    wait_idle();
    chk("R5 ack event done", done, 1);
    clear_flags();
  endtask

  bit finished = 1'b0;

  initial begin
    for (int i = 0; i < 150000 && !finished; i++) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0, p0;
    rst_n = 1'b0; rate = 7'd2;
    {c_start, c_rstart, c_stop, c_rcv, c_ack, c_wr} = '0;
    ack_val = 1'b0; wdata = '0;
    done_clr = 1'b0; wcol_clr = 1'b0; blost_clr = 1'b0;
    slv_sda_low = 1'b0; rival_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 scl released", scl_drv, 0);
    chk("R11 sda released", sda_drv, 0);
    chk("R11 busy", busy, 0);
    chk("R11 flags", {tx_full, done, wcol, blost}, 0);

    // R6 START
    fire(M_START, 8'h00);
    wait_idle();
    chk("R6 start seen on bus", starts, 1);
    chk("R6 lines low after start", {scl_line, sda_line}, 2'b00);
    chk("R7 done after start", done, 1);
    repeat (5) @(negedge clk);
    chk("R7 done held until clear", done, 1);
    clear_flags();
    chk("R7 done cleared", done, 0);

    // R3 write with ACK, R1 refused write, R2 timing, R10 tx_full
    s0 = starts; p0 = stops;
    exp_q.push_back({8'hA5, 1'b0});
    fork
      slave_ack(1'b0);
      begin
        fire(M_WR, 8'hA5);
        chk("R10 tx_full after write", tx_full, 1);
        fire(M_WR, 8'h3C);
        chk("R1 wcol set", wcol, 1);
        chk("R1 no done from refused write", done, 0);
        measure_bit("R2 rate2", 6);
      end
    join
    wait_idle();
    chk("R3 ack sampled", ack_rx, 0);
    chk("R10 tx_full cleared", tx_full, 0);
    chk("R1 buffer kept", rdata, 8'hA5);
    chk("R9 no start inside byte", starts, s0);
    chk("R9 no stop inside byte", stops, p0);
    clear_flags();
    chk("R1 wcol cleared", wcol, 0);

    // R3 write with NACK
    do_write(8'h3C, 1'b1);
    chk("R3 nack sampled", ack_rx, 1);
    clear_flags();

    // R6 repeated START then write
    fire(M_RSTART, 8'h00);
    wait_idle();
    chk("R6 repeated start seen", starts, 2);
    clear_flags();
    do_write(8'h81, 1'b0);
    clear_flags();

    // R4 receive with refused STOP, R5 ACK
    p0 = stops;
    exp_q.push_back({8'h5A, 1'b0});
    slv_sda_low = 1'b1;
    fork
      slave_send(8'h5A);
      begin
        fire(M_RCV, 8'h00);
        fire(M_STOP, 8'h00);
        chk("R1 wcol from stop while busy", wcol, 1);
      end
    join
    wait_idle();
    chk("R4 received 5A", rdata, 8'h5A);
    chk("R1 refused stop left bus alone", stops, p0);
    clear_flags();
    ack_val = 1'b0;
    fire(M_ACK, 8'h00);
    wait_idle();
    clear_flags();

    // R4 / R5 receive with NACK
    do_read(8'hC3, 1'b1);

    // R6 STOP
    fire(M_STOP, 8'h00);
    wait_idle();
    chk("R6 stop seen", stops, p0 + 1);
    chk("R6 lines released after stop", {scl_line, sda_line}, 2'b11);
    clear_flags();

    // R2 at another rate
    rate = 7'd4;
    fire(M_START, 8'h00);
    wait_idle();
    clear_flags();
    exp_q.push_back({8'h96, 1'b0});
    fork
      slave_ack(1'b0);
      begin
        fire(M_WR, 8'h96);
        measure_bit("R2 rate4", 10);
      end
    join
    wait_idle();
    clear_flags();

    // R8 arbitration loss on first bit of a byte with MSB set
    @(negedge clk);
    rival_sda_low = 1'b1;
    fire(M_WR, 8'hC0);
    wait_idle();
    chk("R8 collision flag", blost, 1);
    chk("R8 no done", done, 0);
    chk("R8 tx_full cleared", tx_full, 0);
    chk("R8 lines released", {scl_drv, sda_drv}, 2'b00);
    chk("R8 idle", busy, 0);
    repeat (4) @(negedge clk);
    rival_sda_low = 1'b0;
    clear_flags();
    chk("R8 collision cleared", blost, 0);
    chk("R3 all frames seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule